// File: doc/BRIEF.md
# Maskable Error Interrupt Controller

This block collects the error events of a cipher unit's host interface into a 64-bit sticky status register. A companion 64-bit mask register selects which of those errors are acted upon. An unmasked error sets its status bit, raises an interrupt line and asserts a halt output that freezes the unit's processing. A masked error leaves no trace: its status bit is not written and the interrupt is not raised on its account. Software reads both registers through a small register port and acknowledges errors by writing ones to the status bits it wants cleared.

Error events come from several sources:
- Two byte FIFOs, 256 entries each by default. The input FIFO is fed by the host and drained by the cipher core. The output FIFO is filled by the core and drained by the host.
- An IV-read strobe.
- An ICV compare port.
- Fault strobes from the core.

The FIFOs exist so that overflow and underflow events arise naturally. The cipher datapath is not part of the block.

The host stream ports use valid/ready naming, but on the host side they carry no back-pressure guarantee. `in_ready` only tells the host whether the input FIFO has room. Asserting `in_valid` while `in_ready` is low is an overflow error, and the byte is dropped. `out_valid` tells the host that a byte is available. Asserting `out_ready` while `out_valid` is low is an underflow error, and nothing is removed.

Top module: `err_irq_ctrl`

## Requirements
Register bits below are indexed LSB = 0. For each error, the index is given with its MSB-first position in brackets:
- integrity check 14 [49]
- internal fault 12 [51]
- early IV read 11 [52]
- key fault 9 [54]
- size fault 8 [55]
- mode fault 7 [56]
- input overflow 2 [61]
- output underflow 1 [62]

`reg_sel` = 0 selects status and `reg_sel` = 1 selects mask.

- R1: After reset, status and mask read 0, `irq` and `halt` are low, `in_ready` is 1 and `out_valid` is 0.
- R2: An error event whose mask bit is 0 sets its status bit on the next clock edge, and `irq` and `halt` are then high.
- R3: An error event whose mask bit is 1 leaves status unchanged and does not raise `irq`.
- R4: The input FIFO accepts 256 bytes, after which `in_ready` is 0. A push while full drops the byte and sets bit 2. A push while full in the same cycle as `core_pop` is accepted and is not an error.
- R5: Asserting `out_ready` while the output FIFO is empty sets bit 1.
- R6: `iv_read` while `busy` is 1 sets bit 11; while `busy` is 0 it has no effect.
- R7: `icv_check` with `icv_given` different from `icv_calc` sets bit 14; with equal values it has no effect.
- R8: `int_fault`, `key_fault`, `size_fault` and `mode_fault` set bits 12, 9, 8 and 7 respectively.
- R9: Status bits are sticky. A status write clears exactly the bits written as 1, and writing 0 has no effect.
- R10: When an event and a clearing write hit the same status bit in one cycle, the bit ends set.
- R11: Reserved bits (all others) read 0 in both registers, and mask writes to them are discarded.
- R12: Both FIFOs deliver bytes in the order they were written.
- R13: `irq` and `halt` stay high until every status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host pushes a byte into the input FIFO |
| in_ready | output | 1 | Input FIFO has room |
| in_data | input | 8 | Host byte |
| core_pop | input | 1 | Core takes a byte from the input FIFO |
| core_avail | output | 1 | Input FIFO holds a byte |
| core_data | output | 8 | Head byte of the input FIFO |
| core_push | input | 1 | Core writes a byte to the output FIFO |
| core_room | output | 1 | Output FIFO has room |
| core_wdata | input | 8 | Core result byte |
| out_valid | output | 1 | Output FIFO holds a byte |
| out_ready | input | 1 | Host reads a byte from the output FIFO |
| out_data | output | 8 | Head byte of the output FIFO |
| busy | input | 1 | Unit is processing |
| iv_read | input | 1 | Host reads the IV register |
| icv_check | input | 1 | ICV comparison strobe |
| icv_given | input | 32 | Supplied ICV |
| icv_calc | input | 32 | Computed ICV |
| int_fault | input | 1 | Internal fault strobe |
| key_fault | input | 1 | Key fault strobe |
| size_fault | input | 1 | Data-size fault strobe |
| mode_fault | input | 1 | Mode fault strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status, 1 mask |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Error interrupt |
| halt | output | 1 | Processing halt |

## Verification
Two functions can fall in the same clock cycle, and each pairing is forced deliberately.

The first pairing is an error event and the software acknowledge of the same status bit. The bench raises an ICV mismatch in exactly the cycle that writes 1 to bit 14. It then judges that the bit reads back set and that `irq` stays high.

The second pairing is a host push into a full input FIFO together with a core pop. The bench fills the FIFO to 256 bytes and asserts `in_valid` and `core_pop` together. It then expects bit 2 to stay clear and the accepted byte to come out last in order.

// File: rtl/err_pkg.sv
package err_pkg;
  localparam int REG_W = 64;

  // LSB-0 positions of the implemented error flags
  localparam int B_ICV   = 14;
  localparam int B_INT   = 12;
  localparam int B_EARLY = 11;
  localparam int B_KEY   = 9;
  localparam int B_SIZE  = 8;
  localparam int B_MODE  = 7;
  localparam int B_IOVF  = 2;
  localparam int B_OUFL  = 1;

  localparam logic [REG_W-1:0] IMPL_BITS =
      (64'd1 << B_ICV) | (64'd1 << B_INT) | (64'd1 << B_EARLY) |
      (64'd1 << B_KEY) | (64'd1 << B_SIZE) | (64'd1 << B_MODE) |
      (64'd1 << B_IOVF) | (64'd1 << B_OUFL);

  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/err_fifo.sv
module err_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         not_full,
  output logic         not_empty,
  output logic         overflow,
  output logic         underflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic full, empty, do_push, do_pop;

  assign full      = (cnt == FULL_CNT);
  assign empty     = (cnt == '0);
  assign not_full  = !full;
  assign not_empty = !empty;
  assign do_pop    = pop && !empty;
  assign do_push   = push && (!full || pop);
  assign overflow  = push && full && !pop;
  assign underflow = pop && empty;
  assign rdata     = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/err_detect.sv
module err_detect
  import err_pkg::*;
#(
  parameter int ICV_W = 32
) (
  input  logic             busy,
  input  logic             iv_read,
  input  logic             icv_check,
  input  logic [ICV_W-1:0] icv_given,
  input  logic [ICV_W-1:0] icv_calc,
  input  logic             int_fault,
  input  logic             key_fault,
  input  logic             size_fault,
  input  logic             mode_fault,
  input  logic             in_ovf,
  input  logic             out_unf,
  output logic [REG_W-1:0] events
);
  always_comb begin
    events          = '0;
    events[B_ICV]   = icv_check && (icv_given != icv_calc);
    events[B_INT]   = int_fault;
    events[B_EARLY] = iv_read && busy;
    events[B_KEY]   = key_fault;
    events[B_SIZE]  = size_fault;
    events[B_MODE]  = mode_fault;
    events[B_IOVF]  = in_ovf;
    events[B_OUFL]  = out_unf;
  end
endmodule

// File: rtl/err_regs.sv
module err_regs
  import err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] events,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             any_err
);
  logic [REG_W-1:0] status, mask, clr, setv;

  assign clr  = (reg_wr && reg_sel == SEL_STATUS) ? (reg_wdata & IMPL_BITS) : '0;
  assign setv = events & ~mask & IMPL_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr) | setv;
      if (reg_wr && reg_sel == SEL_MASK) mask <= reg_wdata & IMPL_BITS;
    end
  end

  assign reg_rdata = (reg_sel == SEL_MASK) ? mask : status;
  assign any_err   = |status;

  // R2
  unmasked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((events & ~mask & IMPL_BITS) != '0) |=>
      ((status & $past(events & ~mask & IMPL_BITS)) == $past(events & ~mask & IMPL_BITS)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(mask)) == '0));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status) & ~$past(reg_wr && reg_sel == SEL_STATUS ? reg_wdata : '0)) == '0));

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status | mask) & ~IMPL_BITS) == '0);
endmodule

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl
  import err_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int ICV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             core_pop,
  output logic             core_avail,
  output logic [DW-1:0]    core_data,
  input  logic             core_push,
  output logic             core_room,
  input  logic [DW-1:0]    core_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  input  logic             busy,
  input  logic             iv_read,
  input  logic             icv_check,
  input  logic [ICV_W-1:0] icv_given,
  input  logic [ICV_W-1:0] icv_calc,
  input  logic             int_fault,
  input  logic             key_fault,
  input  logic             size_fault,
  input  logic             mode_fault,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             halt
);
  logic in_ovf, in_unf_unused, out_ovf_unused, out_unf, any_err;
  logic [REG_W-1:0] events;

  err_fifo #(.W(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .wdata(in_data),
    .pop(core_pop), .rdata(core_data),
    .not_full(in_ready), .not_empty(core_avail),
    .overflow(in_ovf), .underflow(in_unf_unused)
  );

  err_fifo #(.W(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(core_push), .wdata(core_wdata),
    .pop(out_ready), .rdata(out_data),
    .not_full(core_room), .not_empty(out_valid),
    .overflow(out_ovf_unused), .underflow(out_unf)
  );

  err_detect #(.ICV_W(ICV_W)) u_detect (
    .busy(busy), .iv_read(iv_read),
    .icv_check(icv_check), .icv_given(icv_given), .icv_calc(icv_calc),
    .int_fault(int_fault), .key_fault(key_fault),
    .size_fault(size_fault), .mode_fault(mode_fault),
    .in_ovf(in_ovf), .out_unf(out_unf),
    .events(events)
  );

  err_regs u_regs (
    .clk(clk), .rst_n(rst_n), .events(events),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .any_err(any_err)
  );

  assign irq  = any_err;
  assign halt = any_err;

  // R13
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reg_wr) |=> halt);
endmodule

// File: tb/err_irq_ctrl_test.sv
module err_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, core_pop = 0, core_push = 0, out_ready = 0;
  logic [7:0] in_data = 0, core_wdata = 0;
  logic busy = 0, iv_read = 0, icv_check = 0;
  logic [31:0] icv_given = 0, icv_calc = 0;
  logic int_fault = 0, key_fault = 0, size_fault = 0, mode_fault = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic in_ready, core_avail, core_room, out_valid, irq, halt;
  logic [7:0] core_data, out_data;
  logic [63:0] reg_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [63:0] IMPL = 64'h5B86;

  // {masked, code[2:0], expected status}
  localparam logic [67:0] VEC [14] = '{
    {1'b0, 3'd0, 64'h4000}, {1'b0, 3'd1, 64'h1000}, {1'b0, 3'd2, 64'h0800},
    {1'b0, 3'd3, 64'h0200}, {1'b0, 3'd4, 64'h0100}, {1'b0, 3'd5, 64'h0080},
    {1'b0, 3'd6, 64'h0002},
    {1'b1, 3'd0, 64'h0}, {1'b1, 3'd1, 64'h0}, {1'b1, 3'd2, 64'h0},
    {1'b1, 3'd3, 64'h0}, {1'b1, 3'd4, 64'h0}, {1'b1, 3'd5, 64'h0},
    {1'b1, 3'd6, 64'h0}
  };

  err_irq_ctrl uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regwrite(input logic sel, input logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_sel = 0; reg_wdata = 0;
  endtask

  task automatic set_event(input logic [2:0] code, input logic v);
    case (code)
      3'd0: begin icv_check = v; icv_given = v ? 32'd1 : 0; icv_calc = v ? 32'd2 : 0; end
      3'd1: int_fault = v;
      3'd2: begin iv_read = v; busy = v; end
      3'd3: key_fault = v;
      3'd4: size_fault = v;
      3'd5: mode_fault = v;
      default: out_ready = v;
    endcase
  endtask

  task automatic fire(input logic [2:0] code);
    @(negedge clk); set_event(code, 1);
    @(negedge clk); set_event(code, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 0; #1 chk("R1 status", reg_rdata, 0);
    reg_sel = 1; #1 chk("R1 mask", reg_rdata, 0);
    reg_sel = 0;
    chk("R1 irq/halt", {irq, halt}, 0);
    chk("R1 in_ready/out_valid", {in_ready, out_valid}, 2'b10);

    // Table: R2/R3/R5/R6/R7/R8
    for (int i = 0; i < 14; i++) begin
      regwrite(1, VEC[i][67] ? '1 : '0);
      fire(VEC[i][66:64]);
      chk(VEC[i][67] ? "R3 masked status" : "R2/R8 status", reg_rdata, VEC[i][63:0]);
      chk(VEC[i][67] ? "R3 masked irq" : "R2 irq", {irq, halt}, (VEC[i][63:0] != 0) ? 2'b11 : 2'b00);
      regwrite(0, '1);
      regwrite(1, 0);
    end

    // R6 idle IV read, R7 matching ICV
    @(negedge clk); iv_read = 1;
    @(negedge clk); iv_read = 0; icv_check = 1; icv_given = 32'h55; icv_calc = 32'h55;
    @(negedge clk); icv_check = 0;
    chk("R6/R7 no effect", reg_rdata, 0);

    // R11 mask reserved bits
    regwrite(1, '1);
    reg_sel = 1; #1 chk("R11 mask readback", reg_rdata, IMPL);
    reg_sel = 0;
    regwrite(1, 0);

    // R4 input FIFO fill
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'(i);
    end
    @(negedge clk); in_valid = 0;
    chk("R4 in_ready when full", in_ready, 0);
    // push while full with a pop: accepted
    @(negedge clk); in_valid = 1; in_data = 8'hEE; core_pop = 1;
    @(negedge clk); in_valid = 0; core_pop = 0;
    chk("R4 push+pop at full no error", reg_rdata, 0);
    // push while full: overflow
    @(negedge clk); in_valid = 1; in_data = 8'h77;
    @(negedge clk); in_valid = 0;
    chk("R4 overflow bit", reg_rdata, 64'h4);
    regwrite(0, 64'h4);
    // R12 drain order: 1..255 then EE
    begin
      int bad = 0;
      for (int i = 1; i < 256; i++) begin
        if (core_data !== 8'(i)) bad++;
        @(negedge clk); core_pop = 1;
        @(negedge clk); core_pop = 0;
      end
      chk("R12 input order", bad, 0);
    end
    chk("R12 last accepted byte", core_data, 8'hEE);
    @(negedge clk); core_pop = 1;
    @(negedge clk); core_pop = 0;
    chk("R12 input empty", core_avail, 0);

    // R12 output FIFO order
    @(negedge clk); core_push = 1; core_wdata = 8'hA1;
    @(negedge clk); core_wdata = 8'hB2;
    @(negedge clk); core_push = 0;
    chk("R12 out first", {out_valid, out_data}, {1'b1, 8'hA1});
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    chk("R12 out second", out_data, 8'hB2);
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    chk("R5 no underflow on valid reads", {out_valid, reg_rdata}, 65'd0);

    // R10 set wins over clear in same cycle
    fire(3'd0);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 64'h4000;
    set_event(3'd0, 1);
    @(negedge clk); reg_wr = 0; reg_wdata = 0; set_event(3'd0, 0);
    chk("R10 set wins", reg_rdata, 64'h4000);

    // R9 sticky, write 0 no effect, partial clear; R13 hold
    fire(3'd1);
    regwrite(0, 0);
    chk("R9 write zero", reg_rdata, 64'h5000);
    regwrite(0, 64'h4000);
    chk("R9 partial clear", reg_rdata, 64'h1000);
    chk("R13 halt held", {irq, halt}, 2'b11);
    regwrite(0, 64'h1000);
    chk("R13 released", {irq, halt}, 2'b00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule